// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block is the sequencing core of a hot-swap controller. It turns the pass switch of a board's supply path on and off and drives an active-low fault flag. A digital up/down ramp counter stands in for the usual timing capacitor. The counter charges by one count per clock while the switch reports current limit, and it discharges by one count per clock otherwise. When the counter reaches its upper threshold, the fault timer has expired and the switch is shut down.

A mode input selects one of two fault policies.

- **Latching policy:** the switch stays off and the flag stays low until the enable input is removed or the supply reports undervoltage lockout.
- **Retry policy:** the ramp counter first falls to a lower threshold. It then makes sixteen full rise-and-fall trips between the two thresholds as a cool-down, and the switch is then switched on again. Under a persistent overload the flag therefore forms a train of low pulses.

Four other sources can also turn the switch off: enable low, overvoltage, overtemperature and lockout. These take priority over every fault state, and the fault flag is never asserted for any of them.

Top module: `hsw_fault_sup`

## Requirements
- R1: While `rst_n` is low, `sw_on` is 0 and `flt_n` is 1. After reset is released with `en` high and no inhibit input active, `sw_on` becomes 1 one clock later, with the ramp counter at zero.
- R2: While the switch is on, the ramp counter rises by one per clock when `ilim` is 1 and falls by one per clock (never below zero) when `ilim` is 0. Starting from zero, T_HI consecutive limit clocks turn `sw_on` to 0 and drive `flt_n` to 0 on the T_HI-th clock edge; T_HI-1 clocks do not.
- R3: With the latching policy (`retry_mode` = 0 when sampled), the switch stays off after a timeout and `flt_n` stays 0 whatever `ilim` does. This lasts until `en` goes low or `uvlo` goes high.
- R4: With the retry policy (`retry_mode` = 1 when sampled), `flt_n` stays 0 for exactly (2·CYC_N+1)·(T_HI−T_LO) clocks after a timeout. On the following clock `sw_on` returns to 1, `flt_n` returns to 1, and the ramp counter restarts from zero.
- R5: Under the retry policy with `ilim` held at 1, each restart is followed by another timeout T_HI clocks later, so `flt_n` becomes a repeating pulse train.
- R6: Any of `en` = 0, `ov` = 1, `ot` = 1 or `uvlo` = 1 forces `sw_on` = 0 and `flt_n` = 1 on the next clock, from any state, including both fault states.
- R7: `en` = 0 or `uvlo` = 1 clears the ramp counter and the cool-down cycle count. After such an event, a later overload again needs a full T_HI limit clocks to trip.
- R8: Clocks without current limit between limit clocks drain the counter. After T_HI−1 limit clocks, one clock out of limit delays the trip by exactly one further limit clock.
- R9: `retry_mode` is sampled only while the switch is in its idle off state. A change made while the switch is on or cooling down does not alter the policy of the sequence in progress.
- R10: A shutdown caused by overvoltage or overtemperature while the ramp counter is partly charged leaves `flt_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low turns the switch off and clears the fault state |
| ov | input | 1 | Overvoltage indication; high turns the switch off |
| ot | input | 1 | Overtemperature indication; high turns the switch off |
| uvlo | input | 1 | Supply undervoltage lockout; high turns the switch off and clears the fault state |
| ilim | input | 1 | Switch is operating in current limit |
| retry_mode | input | 1 | Fault policy: 0 latching, 1 retry |
| sw_on | output | 1 | Pass-switch enable |
| flt_n | output | 1 | Active-low fault flag, asserted only for timer shutdowns |

## Verification
The bench targets the exact trip clock. A counter that compares one step early or late would shut down after T_HI−1 or T_HI+1 limit clocks. It also targets the drain case, where a counter that reset, rather than decremented, when the limit dropped would trip far too late. The cool-down length is measured clock by clock, so an off-by-one in the cycle count, or counting the first discharge as a full cycle, shows up as a wrong pulse width. Further tests toggle the mode input in the middle of a sequence, raise each inhibit source while a fault is held, and pulse lockout over a partly charged counter. A design that sampled the mode continuously, let the fault flag follow an overvoltage shutdown, or kept stale timer charge across lockout would each fail one of these tests.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_LATCH = 2'd2,
        ST_COOL  = 2'd3
    } hsw_state_e;

    typedef enum logic [2:0] {
        RC_HOLD = 3'd0,
        RC_CLR  = 3'd1,
        RC_INC  = 3'd2,
        RC_DEC  = 3'd3,
        RC_LOAD = 3'd4
    } ramp_cmd_e;

    typedef enum logic [1:0] {
        CC_HOLD = 2'd0,
        CC_CLR  = 2'd1,
        CC_INC  = 2'd2
    } cyc_cmd_e;

    typedef struct packed {
        hsw_state_e st;
        logic       dir_up;
        logic       retry;
    } hsw_ctl_t;

endpackage

// File: rtl/hsw_ramp_timer.sv
module hsw_ramp_timer
    import hsw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_HI  = 32,
    parameter int T_LO  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ramp_cmd_e        cmd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             near_hi_o,
    output logic             near_lo_o
);
    localparam logic [CNT_W-1:0] HI_V     = CNT_W'(T_HI);
    localparam logic [CNT_W-1:0] HI_M1_V  = CNT_W'(T_HI - 1);
    localparam logic [CNT_W-1:0] LO_P1_V  = CNT_W'(T_LO + 1);
    localparam logic [CNT_W-1:0] ZERO_V   = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (cmd_i)
            RC_CLR:  cnt_d = ZERO_V;
            RC_LOAD: cnt_d = HI_V;
            RC_INC:  cnt_d = (cnt_q >= HI_V) ? HI_V : cnt_q + 1'b1;
            RC_DEC:  cnt_d = (cnt_q == ZERO_V) ? ZERO_V : cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO_V;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o     = cnt_q;
    assign near_hi_o = (cnt_q == HI_M1_V);
    assign near_lo_o = (cnt_q == LO_P1_V);

endmodule

// File: rtl/hsw_cycle_cnt.sv
module hsw_cycle_cnt
    import hsw_pkg::*;
#(
    parameter int CYC_N = 16,
    parameter int CYC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cyc_cmd_e         cmd_i,
    output logic [CYC_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CYC_W-1:0] N_V = CYC_W'(CYC_N);

    logic [CYC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (cmd_i)
            CC_CLR:  cnt_d = '0;
            CC_INC:  cnt_d = (cnt_q == N_V) ? N_V : cnt_q + 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign done_o = (cnt_q == N_V);

endmodule

// File: rtl/hsw_fault_sup.sv
module hsw_fault_sup
    import hsw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_HI  = 32,
    parameter int T_LO  = 8,
    parameter int CYC_N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ov,
    input  logic ot,
    input  logic uvlo,
    input  logic ilim,
    input  logic retry_mode,
    output logic sw_on,
    output logic flt_n
);
    localparam int CYC_W = $clog2(CYC_N + 1);

    hsw_ctl_t         ctl_d, ctl_q;
    ramp_cmd_e        rcmd;
    cyc_cmd_e         ccmd;
    logic [CNT_W-1:0] tmr_cnt;
    logic [CYC_W-1:0] cyc_cnt;
    logic             near_hi, near_lo, cyc_done;
    logic             clr_req, inhibit;

    hsw_ramp_timer #(.CNT_W(CNT_W), .T_HI(T_HI), .T_LO(T_LO)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (rcmd),
        .cnt_o     (tmr_cnt),
        .near_hi_o (near_hi),
        .near_lo_o (near_lo)
    );

    hsw_cycle_cnt #(.CYC_N(CYC_N), .CYC_W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (ccmd),
        .cnt_o  (cyc_cnt),
        .done_o (cyc_done)
    );

    assign clr_req = !en || uvlo;
    assign inhibit = clr_req || ov || ot;

    always_comb begin
        ctl_d = ctl_q;
        rcmd  = RC_DEC;
        ccmd  = CC_HOLD;

        // policy is latched only while idle with nothing pending
        if (ctl_q.st == ST_OFF) ctl_d.retry = retry_mode;

        if (clr_req) begin
            ctl_d.st     = ST_OFF;
            ctl_d.dir_up = 1'b0;
            rcmd         = RC_CLR;
            ccmd         = CC_CLR;
        end else if (inhibit) begin
            ctl_d.st     = ST_OFF;
            ctl_d.dir_up = 1'b0;
            ccmd         = CC_CLR;
        end else begin
            unique case (ctl_q.st)
                ST_OFF: begin
                    ctl_d.st = ST_ON;
                end
                ST_ON: begin
                    if (ilim) begin
                        if (near_hi) begin
                            rcmd         = RC_LOAD;
                            ccmd         = CC_CLR;
                            ctl_d.dir_up = 1'b0;
                            ctl_d.st     = ctl_q.retry ? ST_COOL : ST_LATCH;
                        end else begin
                            rcmd = RC_INC;
                        end
                    end
                end
                ST_LATCH: begin
                    rcmd = RC_DEC;
                end
                ST_COOL: begin
                    if (ctl_q.dir_up) begin
                        rcmd = RC_INC;
                        if (near_hi) begin
                            ctl_d.dir_up = 1'b0;
                            ccmd         = CC_INC;
                        end
                    end else if (near_lo) begin
                        if (cyc_done) begin
                            ctl_d.st = ST_ON;
                            rcmd     = RC_CLR;
                            ccmd     = CC_CLR;
                        end else begin
                            rcmd         = RC_DEC;
                            ctl_d.dir_up = 1'b1;
                        end
                    end else begin
                        rcmd = RC_DEC;
                    end
                end
                default: ctl_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_OFF, dir_up: 1'b0, retry: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sw_on = (ctl_q.st == ST_ON);
    assign flt_n = !((ctl_q.st == ST_LATCH) || (ctl_q.st == ST_COOL));

endmodule

// File: rtl/hsw_fault_sup_chk.sv
module hsw_fault_sup_chk
    import hsw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_HI  = 32,
    parameter int CYC_N = 16,
    parameter int CYC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ov,
    input logic             ot,
    input logic             uvlo,
    input logic             ilim,
    input logic             sw_on,
    input logic             flt_n,
    input hsw_state_e       st,
    input logic [CNT_W-1:0] tmr,
    input logic [CYC_W-1:0] cyc
);
    localparam logic [CNT_W-1:0] HI_V    = CNT_W'(T_HI);
    localparam logic [CNT_W-1:0] HI_M1_V = CNT_W'(T_HI - 1);
    localparam logic [CYC_W-1:0] N_V     = CYC_W'(CYC_N);

    logic quiet;
    assign quiet = en && !ov && !ot && !uvlo;

    p_flt_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_n |-> !sw_on);

    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> (!sw_on && flt_n));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || uvlo) |=> (tmr == '0 && cyc == '0));

    p_timeout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && sw_on && ilim && tmr == HI_M1_V) |=> (!sw_on && !flt_n));

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && st == ST_LATCH) |=> (!flt_n && !sw_on));

    p_tmr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= HI_V);

    p_cyc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc <= N_V);

endmodule

bind hsw_fault_sup hsw_fault_sup_chk #(
    .CNT_W (CNT_W),
    .T_HI  (T_HI),
    .CYC_N (CYC_N),
    .CYC_W (CYC_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .ov    (ov),
    .ot    (ot),
    .uvlo  (uvlo),
    .ilim  (ilim),
    .sw_on (sw_on),
    .flt_n (flt_n),
    .st    (ctl_q.st),
    .tmr   (tmr_cnt),
    .cyc   (cyc_cnt)
);

// File: tb/hsw_fault_sup_test.sv
`timescale 1ns/1ps
module hsw_fault_sup_test;
    localparam int T_HI  = 32;
    localparam int T_LO  = 8;
    localparam int CYC_N = 16;
    localparam int COOL_LEN = (2 * CYC_N + 1) * (T_HI - T_LO);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ov = 1'b0, ot = 1'b0, uvlo = 1'b0, ilim = 1'b0, retry_mode = 1'b0;
    logic sw_on, flt_n;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    hsw_fault_sup #(.CNT_W(8), .T_HI(T_HI), .T_LO(T_LO), .CYC_N(CYC_N)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ov(ov), .ot(ot), .uvlo(uvlo),
        .ilim(ilim), .retry_mode(retry_mode), .sw_on(sw_on), .flt_n(flt_n)
    );

    // vector: {en, ov, ot, uvlo, ilim, exp_sw, exp_flt_n}
    localparam logic [6:0] VEC [0:8] = '{
        7'b1000011,
        7'b1100001,
        7'b1000011,
        7'b1010001,
        7'b1000011,
        7'b1001001,
        7'b1000011,
        7'b0000001,
        7'b1000011
    };

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; en = 1'b1; ov = 1'b0; ot = 1'b0; uvlo = 1'b0; ilim = 1'b0;
        retry_mode = mode;
        tick(2);
        chk("R1 sw_on in reset", sw_on, 0);
        chk("R1 flt_n in reset", flt_n, 1);
        rst_n = 1'b1;
        tick(1);
        chk("R1 sw_on after release", sw_on, 1);
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (flt_n == 1'b0 && n < 4 * COOL_LEN) begin
            tick(1);
            n++;
        end
    endtask

    initial begin
        int nlow;
        do_reset(1'b0);

        // table walk: R1, R6 (inhibit sources from the on state)
        for (int i = 0; i < 9; i++) begin
            {en, ov, ot, uvlo, ilim} = VEC[i][6:2];
            tick(1);
            chk(i == 0 ? "R1 table sw_on" : "R6 table sw_on", sw_on, int'(VEC[i][1]));
            chk(i == 0 ? "R1 table flt_n" : "R6 table flt_n", flt_n, int'(VEC[i][0]));
        end

        // R2 / R3: latching trip exactly at T_HI
        do_reset(1'b0);
        ilim = 1'b1;
        tick(T_HI - 1);
        chk("R2 still on at T_HI-1", sw_on, 1);
        tick(1);
        chk("R2 off at T_HI", sw_on, 0);
        chk("R3 flag low at trip", flt_n, 0);
        ilim = 1'b0;
        tick(60);
        chk("R3 flag held", flt_n, 0);
        chk("R3 switch held off", sw_on, 0);
        en = 1'b0;
        tick(1);
        chk("R3 en low releases flag", flt_n, 1);
        chk("R6 en low switch off", sw_on, 0);
        en = 1'b1;
        tick(1);
        chk("R3 restart after en", sw_on, 1);

        // R7: lockout clears partial charge
        do_reset(1'b0);
        ilim = 1'b1;
        tick(T_HI - 2);
        uvlo = 1'b1;
        tick(1);
        chk("R7 lockout off", sw_on, 0);
        chk("R7 lockout no flag", flt_n, 1);
        uvlo = 1'b0; ilim = 1'b0;
        tick(1);
        chk("R7 back on", sw_on, 1);
        ilim = 1'b1;
        tick(T_HI - 1);
        chk("R7 no early trip", sw_on, 1);
        tick(1);
        chk("R7 full trip", flt_n, 0);

        // R8: drain by one clock
        do_reset(1'b0);
        ilim = 1'b1;
        tick(T_HI - 1);
        ilim = 1'b0;
        tick(1);
        chk("R8 on after drain", sw_on, 1);
        ilim = 1'b1;
        tick(1);
        chk("R8 one more limit clock", sw_on, 1);
        tick(1);
        chk("R8 trip", sw_on, 0);
        chk("R8 flag", flt_n, 0);

        // R4 / R5: retry cool-down length and pulse train
        do_reset(1'b1);
        ilim = 1'b1;
        tick(T_HI);
        chk("R4 trip in retry", flt_n, 0);
        count_low(nlow);
        chk("R4 cool-down length", nlow, COOL_LEN);
        chk("R4 restart", sw_on, 1);
        tick(T_HI - 1);
        chk("R5 on before second trip", sw_on, 1);
        tick(1);
        chk("R5 second pulse", flt_n, 0);

        // R6 from a fault state: overtemperature during cool-down
        tick(5);
        ot = 1'b1;
        tick(1);
        chk("R6 ot in cool-down flag", flt_n, 1);
        chk("R6 ot in cool-down sw", sw_on, 0);
        ot = 1'b0;

        // R9: mode change while on keeps latching policy
        do_reset(1'b0);
        retry_mode = 1'b1;
        ilim = 1'b1;
        tick(T_HI);
        chk("R9 trip", flt_n, 0);
        tick(COOL_LEN + 5);
        chk("R9 still latched", flt_n, 0);

        // R9: mode change in cool-down keeps retry policy
        do_reset(1'b1);
        ilim = 1'b1;
        tick(T_HI);
        retry_mode = 1'b0;
        count_low(nlow);
        chk("R9 retry completes", nlow, COOL_LEN);
        chk("R9 restarted", sw_on, 1);

        // R10: overvoltage over a partial charge
        do_reset(1'b1);
        ilim = 1'b1;
        tick(T_HI - 3);
        ov = 1'b1;
        tick(1);
        chk("R10 ov sw", sw_on, 0);
        chk("R10 ov flag", flt_n, 1);
        ov = 1'b0; ot = 1'b1;
        tick(3);
        chk("R10 ot flag", flt_n, 1);
        ot = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule